// File: doc/BRIEF.md
# Power-On Strap Capture and Shared Pad Turnaround

This block owns one pad that does two jobs. Directly after power-on it is an input: the pad driver is held off and the level that the board's pull resistor sets on the pad is sampled into a holding register. That level selects the CPU clock frequency. A high level forces the fastest mode. A low level leaves the choice to two live select inputs. A counter clocked by the reference clock measures the strap window. At its terminal count the sampled level is frozen, the pad driver is turned on, and the reference clock appears on the pad.

The same turnaround event releases a set of downstream clocks. Each clock output has its own enable path. The path is a two-flop synchronizer in that clock's domain, followed by a latch that is transparent only while that clock is low. As a result, a clock output can start or stop only between high phases, and no shortened high pulse reaches a load. The pad's reference clock output is gated through the same kind of cell.

The block suits a clock generator that has few configuration pins. The default window is 28636 reference cycles, which is about 2 ms at 14.318 MHz.

Top module: `strap_pad_ctrl`

## Requirements
- R1: While rst_n is sampled low, pad_oe is 0. Two or more edges of each clock into the reset, pad_out and every gated_clk output are held at 0.
- R2: pad_oe rises at the WINDOW_CYCLES-th rising edge of ref_clk at which rst_n is sampled high. It then stays at 1 until the next reset.
- R3: During reset and during the window, strap_133 is updated on every ref_clk rising edge with the level of pad_in at that edge.
- R4: strap_133 keeps the pad_in level sampled at the turnaround edge (edge number WINDOW_CYCLES). Later changes on pad_in have no effect on it until the next reset.
- R5: freq_code is 2'b10 (133 MHz) when strap_133 is 1. When strap_133 is 0 it is decoded from freq_sel: 2'b10 gives 2'b00 (66 MHz), 2'b11 gives 2'b01 (100 MHz), and 2'b00 or 2'b01 gives 2'b11 (outputs off/test).
- R6: pad_out is high only while pad_oe is 1. Each high pulse on it lasts exactly one half period of ref_clk.
- R7: No gated_clk output has a rising edge between reset release and the rise of pad_oe. Each of its high pulses lasts exactly one half period of its own pll_clk.
- R8: After pad_oe rises, every gated_clk output and pad_out start toggling within a few cycles of their own clock. The delay comes from the two-flop synchronizer and the low-phase latch.
- R9: A new reset restarts the window. The strap follows the pad again, and the turnaround repeats with the new pad level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; clocks the window timer and the strap register |
| rst_n | input | 1 | Power-on reset, active low, sampled synchronously in every domain |
| pad_in | input | 1 | Level seen on the shared pad |
| pad_out | output | 1 | Gated reference clock driven onto the pad after turnaround |
| pad_oe | output | 1 | Pad driver enable; 0 keeps the pad three-stated |
| freq_sel | input | 2 | Live frequency select used when the strap is low |
| strap_133 | output | 1 | Captured strap level |
| freq_code | output | 2 | Decoded CPU clock mode |
| pll_clk | input | N_CLK | Free-running downstream clocks |
| gated_clk | output | N_CLK | Glitch-free gated versions of pll_clk |

## Verification
pad_oe and strap_133 are registered on ref_clk, so the result for edge k is checked 5 ns after that edge, before the inputs change at the next falling edge. freq_code is combinational, and it is checked 2 ns after freq_sel is driven. The gated clocks reach their outputs only after two edges of their own clock plus a low phase. For that reason the bench checks them with edge monitors and does not sample them at fixed cycles. The monitors time every high pulse against that clock's half period, flag any rising edge seen before pad_oe has been observed high, and count the pulses, which must be nonzero by the end of each round.

// File: rtl/strap_pkg.sv
// Shared types for the strap/pad turnaround block.
// Assumes: a two-bit live select and a one-bit strap choose the CPU mode.
package strap_pkg;

    typedef enum logic [1:0] {
        FREQ_66  = 2'b00,
        FREQ_100 = 2'b01,
        FREQ_133 = 2'b10,
        FREQ_OFF = 2'b11
    } freq_code_e;

    // Mode decode: the strap wins; otherwise the upper select bit enables the clocks.
    function automatic freq_code_e decode_mode(input logic strap, input logic [1:0] sel);
        freq_code_e m;
        if (strap)
            m = FREQ_133;
        else if (!sel[1])
            m = FREQ_OFF;
        else if (sel[0])
            m = FREQ_100;
        else
            m = FREQ_66;
        return m;
    endfunction

endpackage

// File: rtl/por_window_timer.sv
// Counts reference cycles after reset release and raises a sticky done flag
// at the terminal count. Assumes: rst_n is synchronous, active low.
module por_window_timer #(
    parameter int WINDOW_CYCLES = 28636
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);
    localparam logic [CW-1:0] TERM = CW'(WINDOW_CYCLES);

    logic [CW-1:0] cnt;

    // Advance until the terminal count, then stop and hold done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            cnt  <= cnt + 1'b1;
            done <= (cnt == LAST);
        end
    end

    // R2: once set, done stays set until reset.
    assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R2: done only appears together with a full count.
    assert_done_at_term_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (cnt == TERM));

endmodule

// File: rtl/strap_hold.sv
// Holding register for the strap level: follows the pad while the window is
// open (and in reset), freezes when the window closes.
// Assumes: freeze is sticky until reset.
module strap_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze,
    input  logic pad_level,
    output logic strap_q
);
    // Track the pad each cycle until frozen; reset re-opens tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || !freeze)
            strap_q <= pad_level;
    end

    // R3: while not frozen, the register carries last edge's pad level.
    assert_strap_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(freeze) |-> (strap_q == $past(pad_level)));

    // R4: once frozen, the value never moves.
    assert_strap_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && $past(freeze)) |-> $stable(strap_q));

endmodule

// File: rtl/clk_enable_gate.sv
// Glitch-free clock gate: two-flop synchronizer of the enable into clk's own
// domain, then a latch that is open only while clk is low, ANDed with clk.
// Assumes: en_async may come from any domain; rst_n is synchronous to clk.
module clk_enable_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_async,
    output logic clk_out
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   en_lat;

    // Bring the enable into this clock's domain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], en_async};
    end

    // Pass the enable only during the low phase so no high pulse is cut.
    always_latch begin
        if (!clk)
            en_lat = sync_q[SYNC_STAGES-1];
    end

    assign clk_out = clk & en_lat;

    // R7: at each rising edge the latch holds the synchronizer output.
    assert_latch_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_lat == sync_q[SYNC_STAGES-1]);

endmodule

// File: rtl/strap_pad_ctrl.sv
// Top: shared strap/clock pad with timed turnaround, strap capture, mode
// decode and glitch-free enabling of the reference and downstream clocks.
// Assumes: ref_clk is the reference clock; pll_clk are free-running.
module strap_pad_ctrl
    import strap_pkg::*;
#(
    parameter int WINDOW_CYCLES = 28636,
    parameter int N_CLK         = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oe,
    input  logic [1:0]       freq_sel,
    output logic             strap_133,
    output logic [1:0]       freq_code,
    input  logic [N_CLK-1:0] pll_clk,
    output logic [N_CLK-1:0] gated_clk
);
    logic       window_done;
    freq_code_e mode;

    por_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .done  (window_done)
    );

    strap_hold u_strap (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .freeze    (window_done),
        .pad_level (pad_in),
        .strap_q   (strap_133)
    );

    // The pad driver follows the end of the window directly.
    assign pad_oe = window_done;

    // Reference clock onto the pad, started cleanly.
    clk_enable_gate #(.SYNC_STAGES(SYNC_STAGES)) u_pad_gate (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .en_async (window_done),
        .clk_out  (pad_out)
    );

    // One gate per downstream clock, each synchronized in its own domain.
    for (genvar g = 0; g < N_CLK; g++) begin : g_out
        clk_enable_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk      (pll_clk[g]),
            .rst_n    (rst_n),
            .en_async (window_done),
            .clk_out  (gated_clk[g])
        );
    end

    // Mode from captured strap and live selects.
    always_comb begin
        mode      = decode_mode(strap_133, freq_sel);
        freq_code = mode;
    end

    // R6: the pad never carries a high level while its driver is off.
    assert_pad_quiet_R6: assert property (@(negedge ref_clk) disable iff (!rst_n)
        pad_out |-> pad_oe);

    // R5: a high strap always selects the fastest mode.
    assert_strap_mode_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        strap_133 |-> (freq_code == 2'b10));

endmodule

// File: tb/sim_strap_pad_ctrl.sv
`timescale 1ns/1ps
module sim_strap_pad_ctrl;
    localparam int W = 40;
    localparam int NC = 3;

    logic ref_clk = 1'b0;
    logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0;
    logic rst_n = 1'b0;
    logic pad_in = 1'b0;
    logic [1:0] freq_sel = 2'b00;
    logic pad_out, pad_oe, strap_133;
    logic [1:0] freq_code;
    logic [NC-1:0] pll_clk, gated_clk;

    int total = 0;
    int bad = 0;
    bit oe_seen = 0;
    bit finished = 0;
    int pulses [4];
    logic pad_hist [W+20];

    assign pll_clk = {c2, c1, c0};

    always #10 ref_clk = ~ref_clk;
    always #13 c0 = ~c0;
    initial begin #3; forever #15 c1 = ~c1; end
    always #7 c2 = ~c2;

    strap_pad_ctrl #(.WINDOW_CYCLES(W), .N_CLK(NC)) u0 (
        .ref_clk(ref_clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .freq_sel(freq_sel), .strap_133(strap_133),
        .freq_code(freq_code), .pll_clk(pll_clk), .gated_clk(gated_clk)
    );

    function automatic logic [1:0] exp_mode(input logic s, input logic [1:0] sel);
        if (s) return 2'b10;
        if (!sel[1]) return 2'b11;
        return sel[0] ? 2'b01 : 2'b00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Edge monitors for the three gated clocks and the pad clock (index 3).
    for (genvar g = 0; g < 4; g++) begin : g_mon
        localparam int HALF = (g == 0) ? 13 : (g == 1) ? 15 : (g == 2) ? 7 : 10;
        wire obs = (g < 3) ? gated_clk[g] : pad_out;
        time t_rise = 0;
        bit rise_ok = 0;
        always @(posedge obs) begin
            if ($time > 100 && rst_n === 1'b1) begin
                t_rise = $time;
                rise_ok = 1;
                pulses[g]++;
                // R7 / R6: no pulse before the driver enable was observed.
                check(g < 3 ? "R7 early pulse" : "R6 early pulse", {31'd0, oe_seen}, 32'd1);
            end
        end
        always @(negedge obs) begin
            if (rise_ok) begin
                rise_ok = 0;
                // R7 / R6: full high phase.
                check(g < 3 ? "R7 pulse width" : "R6 pulse width",
                      32'($time - t_rise), 32'(HALF));
            end
        end
    end

    task automatic run_round(input int kind);
        int hold;
        hold = 3 + int'($urandom % 4);
        @(negedge ref_clk);
        rst_n = 1'b0;
        for (int i = 0; i < hold; i++) begin
            @(negedge ref_clk);
            pad_in = $urandom;
            @(posedge ref_clk); #5;
            check("R3 reset follow", {31'd0, strap_133}, {31'd0, pad_in});
            check("R1 oe in reset", {31'd0, pad_oe}, 32'd0);
        end
        repeat (3) @(posedge ref_clk);
        #5;
        check("R1 pad_out low", {31'd0, pad_out}, 32'd0);
        check("R1 gated low", {29'd0, gated_clk}, 32'd0);
        for (int g = 0; g < 4; g++) pulses[g] = 0;
        @(negedge ref_clk);
        oe_seen = 0;
        rst_n = 1'b1;
        for (int k = 1; k <= W + 12; k++) begin
            if (k > 1) @(negedge ref_clk);
            if (kind == 0) pad_in = 1'b1;
            else if (kind == 1) pad_in = 1'b0;
            else pad_in = $urandom;
            pad_hist[k] = pad_in;
            @(posedge ref_clk); #5;
            check("R2 oe timing", {31'd0, pad_oe}, {31'd0, (k >= W)});
            if (pad_oe === 1'b1) oe_seen = 1;
            if (k <= W)
                check("R3 strap follow", {31'd0, strap_133}, {31'd0, pad_hist[k]});
            else
                check("R4 strap frozen", {31'd0, strap_133}, {31'd0, pad_hist[W]});
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge ref_clk);
            freq_sel = (i < 4) ? 2'(i) : 2'($urandom);
            pad_in = $urandom;
            #2;
            check("R5 mode", {30'd0, freq_code}, {30'd0, exp_mode(pad_hist[W], freq_sel)});
        end
        for (int g = 0; g < 4; g++)
            check("R8 started", {31'd0, (pulses[g] > 0)}, 32'd1);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        for (int r = 0; r < 8; r++)
            run_round(r);            // R9: each round restarts the window
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule